// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address by reading translation descriptors from memory. A request brings a translation table base value and a virtual address. The walker reads one first-level descriptor. That descriptor either ends the walk as a 1MB or 16MB block, reports a fault, or points to a second-level table. In the last case the walker reads one more descriptor, which yields a 64KB page, a 4KB page or a fault.

The walker works on one request at a time. It uses a single word-read memory port. That port keeps its request and address steady until the memory answers with a one-cycle data strobe. The result comes back with a one-cycle done pulse. It carries the physical address, a page-size code, an execute-never flag and a fault indication that names the failing level. Permission checks, domains, translation caching and cache behaviour are handled elsewhere.

Top module: `ttw_walker`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done` and `mem_req` are low.
- R2: The first read address is {TTB[31:14], VA[31:20], 2'b00}.
- R3: A first-level descriptor whose bits[1:0] are 00 or 11 ends the walk after one read. It reports `fault`=1 and `fault_l2`=0, with `pa`=0, `size`=0 and `xn`=0.
- R4: A first-level descriptor whose bits[1:0] are 10 and whose bit 18 is 0 gives `pa` = {D[31:20], VA[19:0]} and `size` code 2 (1MB), with no second read.
- R5: A first-level descriptor whose bits[1:0] are 10 and whose bit 18 is 1 gives `pa` = {D[31:24], VA[23:0]} and `size` code 3 (16MB), with no second read.
- R6: A first-level descriptor whose bits[1:0] are 01 leads to exactly one second read, at address {D1[31:10], VA[19:12], 2'b00}.
- R7: A second-level descriptor whose bits[1:0] are 01 gives `pa` = {D2[31:16], VA[15:0]} and `size` code 1 (64KB).
- R8: A second-level descriptor with bit 1 set gives `pa` = {D2[31:12], VA[11:0]}, `size` code 0 (4KB) and `xn` = D2 bit 0. `xn` is 0 for every other outcome.
- R9: A second-level descriptor whose bits[1:0] are 00 reports `fault`=1 and `fault_l2`=1, with `pa`=0 and `xn`=0.
- R10: `busy` rises in the cycle after a request is accepted from idle. It stays high through the done cycle, and `done` lasts exactly one cycle. A `req_valid` seen while busy is ignored.
- R11: `mem_req` and `mem_addr` stay unchanged from the cycle a read starts until the cycle `mem_rvalid` answers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a walk; taken only when idle |
| req_ttb | input | 32 | Translation table base value |
| req_va | input | 32 | Virtual address to translate |
| busy | output | 1 | Walk in progress, including the done cycle |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor word address |
| mem_rvalid | input | 1 | One-cycle read answer strobe |
| mem_rdata | input | 32 | Descriptor data, valid with mem_rvalid |
| done | output | 1 | One-cycle result strobe |
| fault | output | 1 | Translation fault |
| fault_l2 | output | 1 | Fault found at the second level (0 = first level) |
| xn | output | 1 | Execute-never for 4KB pages |
| size | output | 2 | 0 = 4KB, 1 = 64KB, 2 = 1MB, 3 = 16MB |
| pa | output | 32 | Physical address |

## Verification
The bench drives first-level type 11 next to type 00. A decoder that treats 11 as a block would return an address instead of a fault. It checks descriptor bit 18 in both states. Reading the wrong split would mix descriptor bits into the 1MB offset or drop them from the 16MB one. It covers second-level descriptors with bit 0 both set and clear under bit 1. A walker that confuses the large-page and small-page codes, or leaks bit 0 into `xn` for non-4KB results, would show a wrong size or flag. Further tests hold `req_valid` high through a whole walk and stretch memory latency. A walker that restarts on a busy request, or moves its address before the answer, would issue extra or wrong reads.

// File: rtl/ttw_pkg.sv
package ttw_pkg;
    localparam int ADDR_W    = 32;
    localparam int TTB_KEEP  = 18;
    localparam int L1_IDX_W  = 12;
    localparam int L2_IDX_W  = 8;
    localparam int L2_BASE_W = 22;
    localparam int WORD_OFS  = 2;

    typedef enum logic [1:0] {
        SZ_4K  = 2'd0,
        SZ_64K = 2'd1,
        SZ_1M  = 2'd2,
        SZ_16M = 2'd3
    } pg_size_e;

    typedef enum logic [1:0] {
        L1K_FAULT = 2'd0,
        L1K_TABLE = 2'd1,
        L1K_BLOCK = 2'd2
    } l1_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH1 = 2'd1,
        ST_FETCH2 = 2'd2,
        ST_FINISH = 2'd3
    } walk_st_e;

    typedef struct packed {
        logic              fault;
        logic              fault_l2;
        pg_size_e          size;
        logic              xn;
        logic [ADDR_W-1:0] pa;
    } walk_res_t;

    function automatic logic [ADDR_W-1:0] l1_fetch_addr(
        input logic [TTB_KEEP-1:0] base,
        input logic [ADDR_W-1:0]   va
    );
        return {base, va[ADDR_W-1 -: L1_IDX_W], {WORD_OFS{1'b0}}};
    endfunction

    function automatic logic [ADDR_W-1:0] l2_fetch_addr(
        input logic [L2_BASE_W-1:0] base,
        input logic [ADDR_W-1:0]    va
    );
        return {base, va[ADDR_W-L1_IDX_W-1 -: L2_IDX_W], {WORD_OFS{1'b0}}};
    endfunction
endpackage

// File: rtl/ttw_l1_decode.sv
module ttw_l1_decode
    import ttw_pkg::*;
(
    input  logic [ADDR_W-1:0] desc,
    input  logic [ADDR_W-1:0] va,
    output l1_kind_e          kind,
    output walk_res_t         res
);
    logic unused_bits;
    assign unused_bits = ^{desc[19], desc[17:2], va[31:24]};

    always_comb begin
        res  = '0;
        kind = L1K_FAULT;
        unique case (desc[1:0])
            2'b01: kind = L1K_TABLE;
            2'b10: begin
                kind = L1K_BLOCK;
                if (desc[18]) begin
                    res.size = SZ_16M;
                    res.pa   = {desc[31:24], va[23:0]};
                end else begin
                    res.size = SZ_1M;
                    res.pa   = {desc[31:20], va[19:0]};
                end
            end
            default: res.fault = 1'b1;
        endcase
    end
endmodule

// File: rtl/ttw_l2_decode.sv
module ttw_l2_decode
    import ttw_pkg::*;
(
    input  logic [ADDR_W-1:0] desc,
    input  logic [ADDR_W-1:0] va,
    output walk_res_t         res
);
    logic unused_bits;
    assign unused_bits = ^{desc[11:2], va[31:16]};

    always_comb begin
        res = '0;
        if (desc[1]) begin
            res.size = SZ_4K;
            res.pa   = {desc[31:12], va[11:0]};
            res.xn   = desc[0];
        end else if (desc[0]) begin
            res.size = SZ_64K;
            res.pa   = {desc[31:16], va[15:0]};
        end else begin
            res.fault    = 1'b1;
            res.fault_l2 = 1'b1;
        end
    end
endmodule

// File: rtl/ttw_walker.sv
module ttw_walker
    import ttw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_ttb,
    input  logic [ADDR_W-1:0] req_va,
    output logic              busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              done,
    output logic              fault,
    output logic              fault_l2,
    output logic              xn,
    output logic [1:0]        size,
    output logic [ADDR_W-1:0] pa
);
    walk_st_e              state;
    logic [TTB_KEEP-1:0]   ttb_q;
    logic [ADDR_W-1:0]     va_q;
    logic [L2_BASE_W-1:0]  base_q;
    walk_res_t             res_q;

    l1_kind_e              l1_kind;
    walk_res_t             l1_res;
    walk_res_t             l2_res;

    ttw_l1_decode u_l1 (
        .desc (mem_rdata),
        .va   (va_q),
        .kind (l1_kind),
        .res  (l1_res)
    );

    ttw_l2_decode u_l2 (
        .desc (mem_rdata),
        .va   (va_q),
        .res  (l2_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            ttb_q  <= '0;
            va_q   <= '0;
            base_q <= '0;
            res_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        ttb_q <= req_ttb[ADDR_W-1 -: TTB_KEEP];
                        va_q  <= req_va;
                        state <= ST_FETCH1;
                    end
                end
                ST_FETCH1: begin
                    if (mem_rvalid) begin
                        if (l1_kind == L1K_TABLE) begin
                            base_q <= mem_rdata[ADDR_W-1 -: L2_BASE_W];
                            state  <= ST_FETCH2;
                        end else begin
                            res_q <= l1_res;
                            state <= ST_FINISH;
                        end
                    end
                end
                ST_FETCH2: begin
                    if (mem_rvalid) begin
                        res_q <= l2_res;
                        state <= ST_FINISH;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state != ST_IDLE);
    assign done     = (state == ST_FINISH);
    assign mem_req  = (state == ST_FETCH1) || (state == ST_FETCH2);
    assign mem_addr = (state == ST_FETCH2) ? l2_fetch_addr(base_q, va_q)
                                           : l1_fetch_addr(ttb_q, va_q);
    assign fault    = res_q.fault;
    assign fault_l2 = res_q.fault_l2;
    assign xn       = res_q.xn;
    assign size     = res_q.size;
    assign pa       = res_q.pa;
endmodule

// File: rtl/ttw_walker_chk.sv
module ttw_walker_chk
    import ttw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              busy,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rvalid,
    input logic              done,
    input logic              fault,
    input logic              fault_l2,
    input logic              xn,
    input logic [1:0]        size,
    input logic [ADDR_W-1:0] pa
);
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> (busy && mem_req)); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
    AST_DONE_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> busy); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req); // R10
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr))); // R11
    AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (done && fault) |-> (pa == '0 && !xn)); // R3
    AST_L2_FAULT_FLAG: assert property (@(posedge clk) disable iff (rst)
        (done && fault_l2) |-> fault); // R9
    AST_XN_SMALL_ONLY: assert property (@(posedge clk) disable iff (rst)
        (done && xn) |-> (size == 2'd0 && !fault)); // R8
endmodule

bind ttw_walker ttw_walker_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .busy       (busy),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .done       (done),
    .fault      (fault),
    .fault_l2   (fault_l2),
    .xn         (xn),
    .size       (size),
    .pa         (pa)
);

// File: tb/ttw_walker_test.sv
module ttw_walker_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_ttb = '0;
    logic [31:0] req_va = '0;
    logic        busy, mem_req, done, fault, fault_l2, xn;
    logic [31:0] mem_addr, pa;
    logic [1:0]  size;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int fails  = 0;

    logic [31:0] l1_word, l2_word, seen_a1, seen_a2;
    int          mem_lat = 0;
    int          wait_cnt = 0;
    int          rd_count = 0;

    always #5 clk = ~clk;

    ttw_walker uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ttb(req_ttb),
        .req_va(req_va), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .done(done),
        .fault(fault), .fault_l2(fault_l2), .xn(xn), .size(size), .pa(pa)
    );

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        report();
        $finish;
    end

    // memory responder: answers each read after mem_lat idle cycles
    initial begin
        forever begin
            @(negedge clk);
            if (mem_rvalid) begin
                mem_rvalid = 1'b0;
                wait_cnt   = 0;
            end else if (mem_req) begin
                if (wait_cnt >= mem_lat) begin
                    if (rd_count == 0) begin
                        seen_a1   = mem_addr;
                        mem_rdata = l1_word;
                    end else begin
                        seen_a2   = mem_addr;
                        mem_rdata = l2_word;
                    end
                    rd_count++;
                    mem_rvalid = 1'b1;
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    // expected outcome computed from the requirement formulas
    task automatic expect_walk(
        input  logic [31:0] ttb, va, d1, d2,
        output logic [31:0] e_pa, output logic [1:0] e_sz,
        output logic e_xn, e_f, e_f2,
        output logic [31:0] e_a1, e_a2, output int e_rd
    );
        e_pa = '0; e_sz = 2'd0; e_xn = 1'b0; e_f = 1'b0; e_f2 = 1'b0;
        e_a1 = {ttb[31:14], va[31:20], 2'b00};
        e_a2 = '0;
        e_rd = 1;
        if (d1[1:0] == 2'b00 || d1[1:0] == 2'b11) begin
            e_f = 1'b1;
        end else if (d1[1:0] == 2'b10) begin
            if (d1[18]) begin e_pa = {d1[31:24], va[23:0]}; e_sz = 2'd3; end
            else        begin e_pa = {d1[31:20], va[19:0]}; e_sz = 2'd2; end
        end else begin
            e_rd = 2;
            e_a2 = {d1[31:10], va[19:12], 2'b00};
            if (d2[1]) begin
                e_pa = {d2[31:12], va[11:0]}; e_sz = 2'd0; e_xn = d2[0];
            end else if (d2[0]) begin
                e_pa = {d2[31:16], va[15:0]}; e_sz = 2'd1;
            end else begin
                e_f = 1'b1; e_f2 = 1'b1;
            end
        end
    endtask

    task automatic do_walk(input string tag, input logic [31:0] ttb, va, d1, d2,
                           input int lat, input bit rogue);
        logic [31:0] e_pa, e_a1, e_a2;
        logic [1:0]  e_sz;
        logic        e_xn, e_f, e_f2;
        int          e_rd;
        int          n;
        expect_walk(ttb, va, d1, d2, e_pa, e_sz, e_xn, e_f, e_f2, e_a1, e_a2, e_rd);
        l1_word = d1; l2_word = d2; mem_lat = lat; rd_count = 0;
        seen_a1 = 'x; seen_a2 = 'x;
        @(negedge clk);
        req_valid = 1'b1; req_ttb = ttb; req_va = va;
        @(negedge clk);
        req_valid = rogue;
        req_ttb   = ~ttb;
        req_va    = ~va;
        chk({tag, " R10 busy after accept"}, {31'd0, busy}, 32'd1);
        n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        chk({tag, " R10 done seen"}, {31'd0, done}, 32'd1);
        chk({tag, " R10 busy in done cycle"}, {31'd0, busy}, 32'd1);
        chk({tag, " R3/R9 fault"}, {31'd0, fault}, {31'd0, e_f});
        chk({tag, " R9 fault level"}, {31'd0, fault_l2}, {31'd0, e_f2});
        chk({tag, " R4/R5/R7/R8 pa"}, pa, e_pa);
        chk({tag, " R4/R5/R7/R8 size"}, {30'd0, size}, {30'd0, e_sz});
        chk({tag, " R8 xn"}, {31'd0, xn}, {31'd0, e_xn});
        chk({tag, " R2 first read addr"}, seen_a1, e_a1);
        chk({tag, " R6 read count"}, rd_count, e_rd);
        if (e_rd == 2) chk({tag, " R6 second read addr"}, seen_a2, e_a2);
        @(negedge clk);
        chk({tag, " R10 done one cycle"}, {31'd0, done}, 32'd0);
        chk({tag, " R10 idle after done"}, {30'd0, busy, mem_req}, 32'd0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 in reset", {29'd0, busy, done, mem_req}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", {29'd0, busy, done, mem_req}, 32'd0);
    endtask

    task automatic t_l1_faults();
        do_walk("R3 type00", 32'h8000_4000, 32'h1234_5678, 32'hFFFF_FFFC, 32'h0, 0, 1'b0);
        do_walk("R3 type11", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0003, 32'h0, 1, 1'b0);
    endtask

    task automatic t_blocks();
        do_walk("R4 section", 32'h1234_C000, 32'h4567_89AB, 32'hABC0_0002, 32'h0, 0, 1'b0);
        do_walk("R4 section bit19", 32'h0000_0000, 32'h000F_FFFF, 32'hFFFB_FFFE, 32'h0, 0, 1'b0);
        do_walk("R5 supersection", 32'h0004_0000, 32'h00FE_DCBA, 32'hC504_0002, 32'h0, 2, 1'b0);
    endtask

    task automatic t_pages();
        do_walk("R7 large", 32'hA5A5_8000, 32'h0ABC_DEF0, 32'h1234_5401, 32'h9876_FF01, 0, 1'b0);
        do_walk("R8 small xn1", 32'h0000_4000, 32'hFFFF_FFFF, 32'h8765_43FD, 32'h5555_5FFF, 1, 1'b0);
        do_walk("R8 small xn0", 32'h7777_0000, 32'h3001_2345, 32'h0F0F_0C01, 32'h2468_A002, 0, 1'b0);
    endtask

    task automatic t_l2_fault();
        do_walk("R9 l2 fault", 32'h4000_0000, 32'h89AB_CDEF, 32'hFEDC_B801, 32'hFFFF_FFFC, 0, 1'b0);
    endtask

    task automatic t_busy_ignore();
        do_walk("R10 busy req ignored", 32'h2222_4000, 32'h3456_7890, 32'h6660_0002, 32'h0, 2, 1'b1);
        do_walk("R10 busy req ignored l2", 32'h1111_C000, 32'h0040_1234, 32'h3300_0401, 32'h7777_7003, 1, 1'b1);
    endtask

    task automatic t_slow_mem();
        do_walk("R11 slow memory", 32'hC0DE_4000, 32'h5A5A_5A5A, 32'h4321_0001, 32'hBEEF_0001, 6, 1'b0);
    endtask

    initial begin
        t_reset();
        t_l1_faults();
        t_blocks();
        t_pages();
        t_l2_fault();
        t_busy_ignore();
        t_slow_mem();
        repeat (2) @(negedge clk);
        report();
        $finish;
    end
endmodule